// File: doc/BRIEF.md
# Three-Timer Sticky Status and Enable Register

This block is one 16-bit register that software shares across a group of timers. Each timer has three things in it. The first is an interrupt flag, set by a one-cycle pulse from that timer. The second is a counter-overflow error flag, set by its own pulse. The third is a run enable, driven by a pair of write-one bit positions: one position sets the enable and the other clears it. The flags are sticky, and software clears them by writing a one into their positions. Each timer's interrupt request output is the level of its interrupt flag. A timer therefore cannot raise a new request until software has cleared the old one.

Access goes through a plain synchronous register bus with no back-pressure. A write is accepted in the cycle in which `bus_wr` is high and `bus_addr` equals the register address. A read is requested the same way with `bus_rd`. The read data appears in the next cycle and shows the register as it was in the request cycle, before any write in that cycle takes effect. No handshake is needed because every access completes in one cycle. The timer counters and the interrupt controller are separate blocks.

The register layout is fixed, because software decodes it:

| Bits | Contents |
|------|----------|
| 0 to 2 | Interrupt flags for timers 0 to 2 |
| 4 to 6 | Overflow flags for timers 0 to 2 |
| 8+2i | Enable set position for timer i; reads back the enable |
| 9+2i | Enable clear position for timer i; reads back the enable |
| 3, 7, 14, 15 | Reserved |

Top module: `tmr_stat_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every flag and every enable, so `irq_req`, `tmr_en` and all register bits read as zero.
- R2: A high `irq_evt[i]` at a clock edge sets timer i's interrupt flag (bit i) after that edge. The flag stays set until it is cleared, and `irq_req[i]` follows it.
- R3: An accepted write with bit i at one clears interrupt flag i. Writing a zero to a flag position leaves the flag unchanged.
- R4: A high `ovf_evt[i]` at a clock edge sets overflow flag i, at bit 4+i. The flag is sticky and is cleared only by an accepted write with a one at bit 4+i.
- R5: If an event arrives for a flag in the same cycle as a write-one clear of that flag, the event wins and the flag remains set.
- R6: An accepted write with a one at bit 8+2i and a zero at bit 9+2i sets `tmr_en[i]`.
- R7: An accepted write with a one at bit 9+2i clears `tmr_en[i]`, even if bit 8+2i is also one.
- R8: An accepted write with zeros at both bits 8+2i and 9+2i leaves `tmr_en[i]` unchanged.
- R9: On a read, bits 8+2i and 9+2i both return `tmr_en[i]`. The reserved bits 3, 7, 14 and 15 read as zero, and writing them has no effect.
- R10: Read data arrives one cycle after the request and shows the state from before any write in the request cycle. A write or read at any other address is ignored, and `bus_rdata` is zero in every cycle that does not follow an accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid one cycle after an accepted read |
| irq_evt | input | 3 | Interrupt event pulses, one per timer |
| ovf_evt | input | 3 | Overflow event pulses, one per timer |
| tmr_en | output | 3 | Enable for each timer |
| irq_req | output | 3 | Interrupt request level for each timer |

## Verification
The bench targets the case where a clear and an event land in the same cycle. A design that lets the clear win would drop that interrupt. It writes ones to both positions of an enable pair, where a design that gives the set priority would leave the timer running. It writes all zeros to a pair, where a design that treats a zero as a clear would stop a running timer. It issues a read and a clearing write in the same cycle, where a read path that samples after the update would hide the flag software is about to acknowledge. It also writes to the reserved bits and to a wrong address, where a design with a loose address decode or a leaking reserved bit would show the write.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;

  // Overflow flags start one bit above the interrupt flags plus a reserved bit.
  function automatic int unsigned ovf_base(input int unsigned n);
    return n + 1;
  endfunction

  // Enable pairs start at twice the overflow base.
  function automatic int unsigned en_base(input int unsigned n);
    return 2 * (n + 1);
  endfunction

  function automatic int unsigned irq_pos(input int unsigned i);
    return i;
  endfunction

  function automatic int unsigned ovf_pos(input int unsigned n, input int unsigned i);
    return ovf_base(n) + i;
  endfunction

  function automatic int unsigned set_pos(input int unsigned n, input int unsigned i);
    return en_base(n) + 2 * i;
  endfunction

  function automatic int unsigned clr_pos(input int unsigned n, input int unsigned i);
    return en_base(n) + 2 * i + 1;
  endfunction

  // Bits that carry state for n timers in a w-bit word.
  function automatic logic [31:0] used_mask(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int unsigned i = 0; i < n; i++) begin
      m[irq_pos(i)]    = 1'b1;
      m[ovf_pos(n, i)] = 1'b1;
      m[set_pos(n, i)] = 1'b1;
      m[clr_pos(n, i)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              wr_hit,
  output logic              rd_hit
);

  logic addr_match;

  assign addr_match = (bus_addr == REG_ADDR);
  assign wr_hit     = bus_wr & addr_match;
  assign rd_hit     = bus_rd & addr_match;

endmodule

// File: rtl/tmr_sticky_bank.sv
module tmr_sticky_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);

  // One flop per flag; an arriving event has priority over a clear.
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (rst)         q <= 1'b0;
      else if (evt[g]) q <= 1'b1;
      else if (clr[g]) q <= 1'b0;
    end
    assign flag[g] = q;
  end

endmodule

// File: rtl/tmr_enable_ctl.sv
module tmr_enable_ctl #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] en
);

  // The clear position wins when both positions are written with one.
  for (genvar g = 0; g < N; g++) begin : g_en
    logic q;
    always_ff @(posedge clk) begin
      if (rst)             q <= 1'b0;
      else if (clr_req[g]) q <= 1'b0;
      else if (set_req[g]) q <= 1'b1;
    end
    assign en[g] = q;
  end

endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_stat_pkg::*;
#(
  parameter int unsigned N      = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  logic [N-1:0]      irq_flag,
  input  logic [N-1:0]      ovf_flag,
  input  logic [N-1:0]      en,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] image;

  // Assemble the register image; reserved bits stay zero.
  always_comb begin
    image = '0;
    for (int unsigned i = 0; i < N; i++) begin
      image[irq_pos(i)]    = irq_flag[i];
      image[ovf_pos(N, i)] = ovf_flag[i];
      image[set_pos(N, i)] = en[i];
      image[clr_pos(N, i)] = en[i];
    end
  end

  // Registered read port: present state sampled in the request cycle.
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= image;
    else             rdata <= '0;
  end

endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg
  import tmr_stat_pkg::*;
#(
  parameter int unsigned       N        = 3,
  parameter int unsigned       ADDR_W   = 4,
  parameter int unsigned       DATA_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N-1:0]      irq_evt,
  input  logic [N-1:0]      ovf_evt,
  output logic [N-1:0]      tmr_en,
  output logic [N-1:0]      irq_req
);

  localparam logic [31:0]       USED_MASK = used_mask(N);
  localparam logic [DATA_W-1:0] RSV_MASK  = ~USED_MASK[DATA_W-1:0];

  logic         wr_hit;
  logic         rd_hit;
  logic [N-1:0] irq_clr;
  logic [N-1:0] ovf_clr;
  logic [N-1:0] en_set;
  logic [N-1:0] en_clr;
  logic [N-1:0] irq_flag;
  logic [N-1:0] ovf_flag;

  // Reserved write bits carry no function.
  logic unused_rsv;
  assign unused_rsv = ^(bus_wdata & RSV_MASK);

  tmr_bus_decode #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
  ) u_dec (
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );

  // Split the accepted write word into per-timer requests.
  always_comb begin
    for (int unsigned i = 0; i < N; i++) begin
      irq_clr[i] = wr_hit & bus_wdata[irq_pos(i)];
      ovf_clr[i] = wr_hit & bus_wdata[ovf_pos(N, i)];
      en_set[i]  = wr_hit & bus_wdata[set_pos(N, i)];
      en_clr[i]  = wr_hit & bus_wdata[clr_pos(N, i)];
    end
  end

  tmr_sticky_bank #(.N(N)) u_irq (
    .clk (clk),
    .rst (rst),
    .evt (irq_evt),
    .clr (irq_clr),
    .flag(irq_flag)
  );

  tmr_sticky_bank #(.N(N)) u_ovf (
    .clk (clk),
    .rst (rst),
    .evt (ovf_evt),
    .clr (ovf_clr),
    .flag(ovf_flag)
  );

  tmr_enable_ctl #(.N(N)) u_en (
    .clk    (clk),
    .rst    (rst),
    .set_req(en_set),
    .clr_req(en_clr),
    .en     (tmr_en)
  );

  tmr_read_mux #(
    .N     (N),
    .DATA_W(DATA_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .irq_flag(irq_flag),
    .ovf_flag(ovf_flag),
    .en      (tmr_en),
    .rdata   (bus_rdata)
  );

  assign irq_req = irq_flag;

endmodule

// File: rtl/tmr_stat_reg_chk.sv
module tmr_stat_reg_chk
  import tmr_stat_pkg::*;
#(
  parameter int unsigned       N        = 3,
  parameter int unsigned       ADDR_W   = 4,
  parameter int unsigned       DATA_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 4'h3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N-1:0]      irq_evt,
  input logic [N-1:0]      ovf_evt,
  input logic [N-1:0]      tmr_en,
  input logic [N-1:0]      irq_req
);

  localparam logic [31:0]       USED     = used_mask(N);
  localparam logic [DATA_W-1:0] RSV_MASK = ~USED[DATA_W-1:0];

  logic hit_w;
  logic hit_r;
  assign hit_w = bus_wr && (bus_addr == REG_ADDR);
  assign hit_r = bus_rd && (bus_addr == REG_ADDR);

  logic unused_ovf;
  assign unused_ovf = ^ovf_evt;

  // R1
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && tmr_en == '0 && bus_rdata == '0));

  assert_rsv_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & RSV_MASK) == '0);

  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !hit_r |=> bus_rdata == '0);

  for (genvar g = 0; g < N; g++) begin : g_chk
    localparam int unsigned SP = set_pos(N, g);
    localparam int unsigned CP = clr_pos(N, g);

    assert_irq_sticky_R2: assert property (@(posedge clk) disable iff (rst)
      (irq_req[g] && !(hit_w && bus_wdata[g])) |=> irq_req[g]);

    assert_irq_clear_R3: assert property (@(posedge clk) disable iff (rst)
      (hit_w && bus_wdata[g] && !irq_evt[g]) |=> !irq_req[g]);

    assert_evt_wins_R5: assert property (@(posedge clk) disable iff (rst)
      irq_evt[g] |=> irq_req[g]);

    assert_en_set_R6: assert property (@(posedge clk) disable iff (rst)
      (hit_w && bus_wdata[SP] && !bus_wdata[CP]) |=> tmr_en[g]);

    assert_en_clr_R7: assert property (@(posedge clk) disable iff (rst)
      (hit_w && bus_wdata[CP]) |=> !tmr_en[g]);

    assert_en_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !(hit_w && (bus_wdata[SP] || bus_wdata[CP])) |=> $stable(tmr_en[g]));

    assert_pair_same_R9: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[SP] == bus_rdata[CP]);
  end

endmodule

bind tmr_stat_reg tmr_stat_reg_chk #(
  .N       (N),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .REG_ADDR(REG_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .irq_evt  (irq_evt),
  .ovf_evt  (ovf_evt),
  .tmr_en   (tmr_en),
  .irq_req  (irq_req)
);

// File: tb/tmr_stat_reg_test.sv
module tmr_stat_reg_test;

  localparam logic [3:0] ADDR  = 4'h3;
  localparam logic [3:0] OTHER = 4'h5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  irq_evt = '0;
  logic [2:0]  ovf_evt = '0;
  logic [2:0]  tmr_en;
  logic [2:0]  irq_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  tmr_stat_reg uut (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_evt  (irq_evt),
    .ovf_evt  (ovf_evt),
    .tmr_en   (tmr_en),
    .irq_req  (irq_req)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk) begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
    @(negedge clk) begin bus_wr = 1'b0; bus_wdata = '0; end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk) begin bus_rd = 1'b1; bus_addr = a; end
    @(negedge clk) begin bus_rd = 1'b0; d = bus_rdata; end
  endtask

  task automatic pulse(input logic [2:0] ie, input logic [2:0] oe);
    @(negedge clk) begin irq_evt = ie; ovf_evt = oe; end
    @(negedge clk) begin irq_evt = '0; ovf_evt = '0; end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    pulse(3'b111, 3'b111);
    wr(ADDR, 16'h1500);
    do_reset();
    check("R1 irq_req", {13'd0, irq_req}, 16'h0);
    check("R1 tmr_en", {13'd0, tmr_en}, 16'h0);
    rd(ADDR, d);
    check("R1 read", d, 16'h0000);
  endtask

  task automatic t_irq_latch();
    logic [15:0] d;
    do_reset();
    pulse(3'b010, 3'b000);
    check("R2 set", {13'd0, irq_req}, 16'h0002);
    repeat (5) @(negedge clk);
    check("R2 sticky", {13'd0, irq_req}, 16'h0002);
    rd(ADDR, d);
    check("R2 read", d, 16'h0002);
  endtask

  task automatic t_w1c();
    do_reset();
    pulse(3'b111, 3'b000);
    wr(ADDR, 16'h0000);
    check("R3 zero write", {13'd0, irq_req}, 16'h0007);
    wr(ADDR, 16'h0001);
    check("R3 clear one", {13'd0, irq_req}, 16'h0006);
    wr(ADDR, 16'h0006);
    check("R3 clear rest", {13'd0, irq_req}, 16'h0000);
  endtask

  task automatic t_ovf();
    logic [15:0] d;
    do_reset();
    pulse(3'b000, 3'b101);
    rd(ADDR, d);
    check("R4 set", d, 16'h0050);
    check("R4 no irq", {13'd0, irq_req}, 16'h0000);
    wr(ADDR, 16'h0010);
    rd(ADDR, d);
    check("R4 clear", d, 16'h0040);
  endtask

  task automatic t_race();
    do_reset();
    @(negedge clk) begin
      irq_evt = 3'b001; bus_wr = 1'b1; bus_addr = ADDR; bus_wdata = 16'h0001;
    end
    @(negedge clk) begin irq_evt = '0; bus_wr = 1'b0; bus_wdata = '0; end
    check("R5 event wins", {13'd0, irq_req}, 16'h0001);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    do_reset();
    wr(ADDR, 16'h0100);
    check("R6 set t0", {13'd0, tmr_en}, 16'h0001);
    wr(ADDR, 16'h1000);
    check("R6 set t2", {13'd0, tmr_en}, 16'h0005);
    rd(ADDR, d);
    check("R9 pair readback", d, 16'h3300);
  endtask

  task automatic t_disable();
    do_reset();
    wr(ADDR, 16'h1500);
    wr(ADDR, 16'h0200);
    check("R7 clear t0", {13'd0, tmr_en}, 16'h0006);
    wr(ADDR, 16'h0C00);
    check("R7 both ones", {13'd0, tmr_en}, 16'h0004);
    wr(ADDR, 16'h3000);
    check("R7 both ones t2", {13'd0, tmr_en}, 16'h0000);
  endtask

  task automatic t_hold();
    do_reset();
    wr(ADDR, 16'h0500);
    pulse(3'b111, 3'b111);
    wr(ADDR, 16'h00FF);
    check("R8 flags cleared", {13'd0, irq_req}, 16'h0000);
    check("R8 enable held", {13'd0, tmr_en}, 16'h0003);
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    do_reset();
    pulse(3'b111, 3'b111);
    wr(ADDR, 16'h1500);
    rd(ADDR, d);
    check("R9 full image", d, 16'h3F77);
    wr(ADDR, 16'hC088);
    rd(ADDR, d);
    check("R9 reserved write", d, 16'h3F77);
  endtask

  task automatic t_addr();
    logic [15:0] d;
    do_reset();
    pulse(3'b100, 3'b000);
    wr(OTHER, 16'h0004);
    check("R10 wrong addr write", {13'd0, irq_req}, 16'h0004);
    rd(OTHER, d);
    check("R10 wrong addr read", d, 16'h0000);
    @(negedge clk) begin
      bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = ADDR; bus_wdata = 16'h0004;
    end
    @(negedge clk) begin
      bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0; d = bus_rdata;
    end
    check("R10 pre-write read", d, 16'h0004);
    check("R10 write applied", {13'd0, irq_req}, 16'h0000);
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 16'h0000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_irq_latch();
        t_w1c();
        t_ovf();
        t_race();
        t_enable();
        t_disable();
        t_hold();
        t_reserved();
        t_addr();
      end
      begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule